// File: doc/BRIEF.md
# RTS Hysteresis Flow Controller

This block decides, cycle by cycle, whether a UART receiver should let its link partner keep sending. It watches the fill level of the receive FIFO (0 to 128 characters) and compares it with a programmable receive trigger level. Around that level it places a band whose half-width is picked from a table of sixteen entries. When the FIFO fills past the top of the band, the request-to-send signal is withdrawn. It is given back only once the FIFO has drained to the bottom of the band. Because the two thresholds are apart, the output does not chatter when the fill level wanders near the trigger point.

The block also holds the two trigger levels of the UART, one for receive and one for transmit. Both are written through a single byte-wide write path, and a steering input chooses which of the two a write updates. Only the receive level takes part in flow control. Both stored levels are brought out for the rest of the UART. The `rts` output is active high: 1 means the partner may send.

Top module: `rts_hyst_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `rts` is 1 and both stored trigger levels equal the reset default of 16.
- R2: A write with `trig_wr_to_rx`=1 updates only `rx_trig_lvl`, and a write with `trig_wr_to_rx`=0 updates only `tx_trig_lvl`. The new value is visible one clock after the write edge.
- R3: A written trigger value above 128 is stored as 128. Values from 0 to 128 are stored unchanged.
- R4: The half-width h is selected by `hyst_code`, with bits [3:2] choosing a row and bits [1:0] choosing a column. Codes 0 to 15 give, in order, h = 0 (next-level mode), 4, 6, 8, 8, 16, 24, 32, 12, 20, 28, 36, 40, 44, 48, 52.
- R5: For a nonzero code with auto-RTS enabled, a clock edge at which the count is at least min(trigger+h, 128) drives `rts` to 0 after that edge.
- R6: For a nonzero code with auto-RTS enabled, a clock edge at which `rts` is 0 and the count is at most max(trigger−h, 0) drives `rts` to 1. A count strictly between the two thresholds leaves `rts` unchanged.
- R7: With code 0 and auto-RTS enabled, `rts` goes to 0 when the count is at least the trigger level and returns to 1 when the count is below it. With a trigger level of 0, `rts` therefore stays at 0.
- R8: While `auto_rts_en` is 0, `rts` is 1 one clock later, whatever the count. The controller restarts in the ready state, so re-enabling with a count inside the band keeps `rts` at 1.
- R9: Both thresholds are clamped to the range 0..128. With trigger 126 and h=52, `rts` falls only at count 128. With trigger 3 and h=52, it rises only at count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| auto_rts_en | input | 1 | 1 lets the fill level control `rts` |
| rx_fifo_count | input | 8 | Current receive FIFO fill level, 0..128 |
| trig_wr_en | input | 1 | Trigger-level write strobe |
| trig_wr_to_rx | input | 1 | Write target: 1 receive level, 0 transmit level |
| trig_wr_data | input | 8 | Trigger value to write |
| hyst_code | input | 4 | Hysteresis table index |
| rts | output | 1 | Request-to-send, 1 = partner may send |
| rx_trig_lvl | output | 8 | Stored receive trigger level |
| tx_trig_lvl | output | 8 | Stored transmit trigger level |

## Verification
Every result of this block appears one clock after the edge that samples its cause. A count or enable change is reflected in `rts` right after the next rising edge. A trigger write shows on the level outputs right after its edge, and it moves the thresholds from the edge after that. The bench changes every input on a falling edge, lets exactly one rising edge pass, and compares on the following falling edge. The reference model it compares against is updated at that same rising edge: it takes the flow decision from the trigger level held before the edge and only then applies any write. Ramps up and down the full count range, for each hysteresis code, place the transition counts exactly.

// File: rtl/rts_hyst_pkg.sv
package rts_hyst_pkg;

    localparam int HYST_W = 6;

    typedef enum logic {
        ST_READY = 1'b0,
        ST_HALT  = 1'b1
    } rts_state_e;

    // Half-width of the band: row code[3:2], column code[1:0].
    function automatic logic [HYST_W-1:0] band_of(input logic [3:0] code);
        logic [HYST_W-1:0] col;
        logic [HYST_W-1:0] w;
        col = HYST_W'(code[1:0]);
        case (code[3:2])
            2'd0:    w = (code[1:0] == 2'd0) ? '0 : HYST_W'(2) + (col << 1);
            2'd1:    w = (col + HYST_W'(1)) << 3;
            2'd2:    w = HYST_W'(12) + (col << 3);
            default: w = HYST_W'(40) + (col << 2);
        endcase
        return w;
    endfunction

endpackage

// File: rtl/rts_trig_store.sv
module rts_trig_store #(
    parameter int CNT_W      = 8,
    parameter int DATA_W     = 8,
    parameter int FIFO_DEPTH = 128,
    parameter int RESET_TRIG = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_to_rx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  rx_lvl,
    output logic [CNT_W-1:0]  tx_lvl
);

    localparam logic [DATA_W-1:0] MAX_D = DATA_W'(FIFO_DEPTH);
    localparam logic [CNT_W-1:0]  MAX_C = CNT_W'(FIFO_DEPTH);
    localparam logic [CNT_W-1:0]  RST_C = CNT_W'(RESET_TRIG);

    typedef struct packed {
        logic [CNT_W-1:0] rx;
        logic [CNT_W-1:0] tx;
    } lvl_t;

    lvl_t             lvl_d, lvl_q;
    logic [CNT_W-1:0] wr_val;

    always_comb begin
        lvl_d  = lvl_q;
        wr_val = (wr_data > MAX_D) ? MAX_C : CNT_W'(wr_data);
        if (wr_en) begin
            if (wr_to_rx) lvl_d.rx = wr_val;
            else          lvl_d.tx = wr_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q.rx <= RST_C;
            lvl_q.tx <= RST_C;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    assign rx_lvl = lvl_q.rx;
    assign tx_lvl = lvl_q.tx;

    // R3
    lvl_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q.rx <= MAX_C) && (lvl_q.tx <= MAX_C));

    // R2
    rx_write_spares_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_to_rx) |=> $stable(lvl_q.tx));

    // R2
    tx_write_spares_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_to_rx) |=> $stable(lvl_q.rx));

endmodule

// File: rtl/rts_band_decode.sv
module rts_band_decode
    import rts_hyst_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int FIFO_DEPTH = 128
) (
    input  logic [CNT_W-1:0] trig,
    input  logic [3:0]       code,
    output logic [CNT_W-1:0] hi_thr,
    output logic [CNT_W-1:0] lo_thr,
    output logic             lo_valid
);

    localparam logic [CNT_W:0] MAX_X = (CNT_W+1)'(FIFO_DEPTH);

    logic [HYST_W-1:0] band;
    logic [CNT_W:0]    band_x;
    logic [CNT_W:0]    trig_x;
    logic [CNT_W:0]    sum_x;
    logic [CNT_W:0]    diff_x;

    always_comb begin
        band   = band_of(code);
        band_x = (CNT_W+1)'(band);
        trig_x = {1'b0, trig};
        sum_x  = trig_x + band_x;
        diff_x = trig_x - band_x;
        if (code == 4'd0) begin
            // next-level mode: leave at trig, return below trig
            hi_thr   = trig;
            lo_thr   = trig - CNT_W'(1);
            lo_valid = (trig != '0);
        end else begin
            hi_thr   = (sum_x > MAX_X) ? MAX_X[CNT_W-1:0] : sum_x[CNT_W-1:0];
            lo_thr   = (trig_x > band_x) ? diff_x[CNT_W-1:0] : '0;
            lo_valid = 1'b1;
        end
    end

endmodule

// File: rtl/rts_state_ctrl.sv
module rts_state_ctrl
    import rts_hyst_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int FIFO_DEPTH = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_en,
    input  logic [CNT_W-1:0] fill,
    input  logic [CNT_W-1:0] hi_thr,
    input  logic [CNT_W-1:0] lo_thr,
    input  logic             lo_valid,
    output logic             rts
);

    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(FIFO_DEPTH);

    typedef struct packed {
        rts_state_e st;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic above_hi;
    logic below_lo;

    always_comb begin
        ctl_d    = ctl_q;
        above_hi = (fill >= hi_thr);
        below_lo = lo_valid && (fill <= lo_thr);
        if (!auto_en) begin
            ctl_d.st = ST_READY;
        end else begin
            case (ctl_q.st)
                ST_READY: if (above_hi) ctl_d.st = ST_HALT;
                default:  if (below_lo) ctl_d.st = ST_READY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q.st <= ST_READY;
        else        ctl_q    <= ctl_d;
    end

    assign rts = (ctl_q.st == ST_READY);

    // R5
    halt_at_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && fill >= hi_thr) |=> !rts);

    // R6
    resume_at_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && lo_valid && fill <= lo_thr) |=> rts);

    // R6
    hold_in_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en && fill < hi_thr && !(lo_valid && fill <= lo_thr)) |=> $stable(rts));

    // R8
    manual_keeps_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |=> rts);

    // R9
    thr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_thr <= MAX_C) && (!lo_valid || lo_thr < hi_thr));

endmodule

// File: rtl/rts_hyst_ctrl.sv
module rts_hyst_ctrl #(
    parameter int FIFO_DEPTH = 128,
    parameter int CNT_W      = $clog2(FIFO_DEPTH + 1),
    parameter int DATA_W     = 8,
    parameter int RESET_TRIG = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              auto_rts_en,
    input  logic [CNT_W-1:0]  rx_fifo_count,
    input  logic              trig_wr_en,
    input  logic              trig_wr_to_rx,
    input  logic [DATA_W-1:0] trig_wr_data,
    input  logic [3:0]        hyst_code,
    output logic              rts,
    output logic [CNT_W-1:0]  rx_trig_lvl,
    output logic [CNT_W-1:0]  tx_trig_lvl
);

    logic [CNT_W-1:0] hi_thr;
    logic [CNT_W-1:0] lo_thr;
    logic             lo_valid;

    rts_trig_store #(
        .CNT_W      (CNT_W),
        .DATA_W     (DATA_W),
        .FIFO_DEPTH (FIFO_DEPTH),
        .RESET_TRIG (RESET_TRIG)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (trig_wr_en),
        .wr_to_rx (trig_wr_to_rx),
        .wr_data  (trig_wr_data),
        .rx_lvl   (rx_trig_lvl),
        .tx_lvl   (tx_trig_lvl)
    );

    rts_band_decode #(
        .CNT_W      (CNT_W),
        .FIFO_DEPTH (FIFO_DEPTH)
    ) u_band (
        .trig     (rx_trig_lvl),
        .code     (hyst_code),
        .hi_thr   (hi_thr),
        .lo_thr   (lo_thr),
        .lo_valid (lo_valid)
    );

    rts_state_ctrl #(
        .CNT_W      (CNT_W),
        .FIFO_DEPTH (FIFO_DEPTH)
    ) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .auto_en  (auto_rts_en),
        .fill     (rx_fifo_count),
        .hi_thr   (hi_thr),
        .lo_thr   (lo_thr),
        .lo_valid (lo_valid),
        .rts      (rts)
    );

    // R1
    reset_ready_chk: assert property (@(posedge clk)
        !rst_n |=> rts);

endmodule

// File: tb/tb_rts_hyst_ctrl.sv
`timescale 1ns/1ps
module tb_rts_hyst_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       auto_rts_en;
    logic [7:0] rx_fifo_count;
    logic       trig_wr_en;
    logic       trig_wr_to_rx;
    logic [7:0] trig_wr_data;
    logic [3:0] hyst_code;
    logic       rts;
    logic [7:0] rx_trig_lvl;
    logic [7:0] tx_trig_lvl;

    int n_chk  = 0;
    int n_fail = 0;

    // reference model state
    int   m_rx_trig;
    int   m_tx_trig;
    logic m_rts;

    always #2.5 clk = ~clk;

    rts_hyst_ctrl dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .auto_rts_en   (auto_rts_en),
        .rx_fifo_count (rx_fifo_count),
        .trig_wr_en    (trig_wr_en),
        .trig_wr_to_rx (trig_wr_to_rx),
        .trig_wr_data  (trig_wr_data),
        .hyst_code     (hyst_code),
        .rts           (rts),
        .rx_trig_lvl   (rx_trig_lvl),
        .tx_trig_lvl   (tx_trig_lvl)
    );

    function automatic int half_width(input int code);
        case (code)
            0: return 0;   1: return 4;   2: return 6;   3: return 8;
            4: return 8;   5: return 16;  6: return 24;  7: return 32;
            8: return 12;  9: return 20;  10: return 28; 11: return 36;
            12: return 40; 13: return 44; 14: return 48; default: return 52;
        endcase
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d (count=%0d code=%0d trig=%0d)",
                     tag, got, exp, rx_fifo_count, hyst_code, m_rx_trig);
        end
    endtask

    // One rising edge with model update; called and returns at a falling edge.
    task automatic cycle();
        int cnt;
        int h;
        int hi;
        int lo;
        logic lo_ok;
        @(posedge clk);
        cnt = int'(rx_fifo_count);
        h   = half_width(int'(hyst_code));
        if (hyst_code == 4'd0) begin
            hi = m_rx_trig; lo = m_rx_trig - 1; lo_ok = (m_rx_trig != 0);
        end else begin
            hi = (m_rx_trig + h > 128) ? 128 : m_rx_trig + h;
            lo = (m_rx_trig - h < 0) ? 0 : m_rx_trig - h;
            lo_ok = 1'b1;
        end
        if (!auto_rts_en)                     m_rts = 1'b1;
        else if (m_rts && cnt >= hi)          m_rts = 1'b0;
        else if (!m_rts && lo_ok && cnt <= lo) m_rts = 1'b1;
        if (trig_wr_en) begin
            if (trig_wr_to_rx) m_rx_trig = (trig_wr_data > 8'd128) ? 128 : int'(trig_wr_data);
            else               m_tx_trig = (trig_wr_data > 8'd128) ? 128 : int'(trig_wr_data);
        end
        @(negedge clk);
    endtask

    task automatic write_trig(input logic to_rx, input int val, input string tag);
        trig_wr_en    = 1'b1;
        trig_wr_to_rx = to_rx;
        trig_wr_data  = 8'(val);
        cycle();
        trig_wr_en = 1'b0;
        check({tag, " rx level"}, int'(rx_trig_lvl), m_rx_trig);
        check({tag, " tx level"}, int'(tx_trig_lvl), m_tx_trig);
        check({tag, " rts"}, int'(rts), int'(m_rts));
    endtask

    task automatic step(input int cnt, input string tag);
        rx_fifo_count = 8'(cnt);
        cycle();
        check(tag, int'(rts), int'(m_rts));
    endtask

    task automatic t_reset();
        check("R1 rts in reset", int'(rts), 1);
        check("R1 rx level in reset", int'(rx_trig_lvl), 16);
        check("R1 tx level in reset", int'(tx_trig_lvl), 16);
        rst_n = 1'b1;
        cycle();
        check("R1 rts after release", int'(rts), 1);
        check("R1 rx level after release", int'(rx_trig_lvl), 16);
    endtask

    task automatic t_steer();
        write_trig(1'b1, 40, "R2 write rx");
        check("R2 tx untouched", int'(tx_trig_lvl), 16);
        write_trig(1'b0, 100, "R2 write tx");
        check("R2 rx untouched", int'(rx_trig_lvl), 40);
    endtask

    task automatic t_clamp_write();
        write_trig(1'b1, 200, "R3 rx 200");
        check("R3 rx clamps", int'(rx_trig_lvl), 128);
        write_trig(1'b0, 129, "R3 tx 129");
        check("R3 tx clamps", int'(tx_trig_lvl), 128);
        write_trig(1'b1, 128, "R3 rx 128");
        write_trig(1'b0, 0, "R3 tx 0");
        check("R3 zero kept", int'(tx_trig_lvl), 0);
    endtask

    // Ramp up then down; record where rts falls and rises.
    task automatic sweep(input string tag, output int fall_at, output int rise_at);
        fall_at = -1;
        rise_at = -1;
        for (int c = 0; c <= 128; c++) begin
            step(c, tag);
            if (fall_at < 0 && !rts) fall_at = c;
        end
        for (int c = 128; c >= 0; c--) begin
            step(c, tag);
            if (rise_at < 0 && rts) rise_at = c;
        end
    endtask

    task automatic t_table();
        int f;
        int r;
        write_trig(1'b1, 64, "R4 set trig");
        auto_rts_en = 1'b1;
        for (int code = 1; code < 16; code++) begin
            hyst_code = 4'(code);
            sweep("R5 R6 sweep", f, r);
            check("R4 R5 fall count", f, 64 + half_width(code));
            check("R4 R6 rise count", r, 64 - half_width(code));
        end
    endtask

    task automatic t_next_level();
        hyst_code = 4'd0;
        step(60, "R7 below");
        check("R7 below ready", int'(rts), 1);
        step(63, "R7 just below");
        check("R7 63 ready", int'(rts), 1);
        step(64, "R7 at trig");
        check("R7 at trig halts", int'(rts), 0);
        step(70, "R7 above");
        step(64, "R7 back at trig");
        check("R7 at trig still halted", int'(rts), 0);
        step(63, "R7 below trig");
        check("R7 below trig resumes", int'(rts), 1);
        write_trig(1'b1, 0, "R7 trig zero");
        step(0, "R7 trig zero count zero");
        check("R7 zero trig halts", int'(rts), 0);
        step(0, "R7 zero trig stays");
        check("R7 zero trig never resumes", int'(rts), 0);
        auto_rts_en = 1'b0;
        step(0, "R8 clear");
        auto_rts_en = 1'b1;
    endtask

    task automatic t_edges();
        hyst_code = 4'd15;
        write_trig(1'b1, 126, "R9 high trig");
        for (int c = 100; c <= 127; c++) step(c, "R9 high ramp");
        check("R9 127 still ready", int'(rts), 1);
        step(128, "R9 at 128");
        check("R9 falls at 128", int'(rts), 0);
        write_trig(1'b1, 3, "R9 low trig");
        for (int c = 54; c >= 1; c--) step(c, "R9 low ramp");
        check("R9 1 still halted", int'(rts), 0);
        step(0, "R9 at 0");
        check("R9 rises at 0", int'(rts), 1);
    endtask

    task automatic t_auto();
        write_trig(1'b1, 64, "R8 set trig");
        hyst_code = 4'd1;
        step(100, "R8 overfull");
        check("R8 enabled halts", int'(rts), 0);
        auto_rts_en = 1'b0;
        step(100, "R8 disabled");
        check("R8 disabled ready", int'(rts), 1);
        step(128, "R8 disabled full");
        check("R8 disabled full ready", int'(rts), 1);
        rx_fifo_count = 8'd66;
        auto_rts_en   = 1'b1;
        cycle();
        check("R8 re-enable in band ready", int'(rts), 1);
        step(67, "R8 in band");
        step(68, "R8 upper edge");
        check("R8 halts again", int'(rts), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): got running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n         = 1'b0;
        auto_rts_en   = 1'b0;
        rx_fifo_count = 8'd0;
        trig_wr_en    = 1'b0;
        trig_wr_to_rx = 1'b0;
        trig_wr_data  = 8'd0;
        hyst_code     = 4'd0;
        m_rx_trig     = 16;
        m_tx_trig     = 16;
        m_rts         = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_steer();
        t_clamp_write();
        t_table();
        t_next_level_wrap();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    task automatic t_next_level_wrap();
        write_trig(1'b1, 64, "R7 set trig");
        step(0, "R7 drain");
        t_next_level();
        t_edges();
        t_auto();
    endtask

endmodule